// File: doc/BRIEF.md
# Reset Cause and Supply Monitor Control

This block keeps a record of which event last reset the microcontroller and holds the control state of a supply voltage level monitor. Three single-cycle event pulses come in: power-on, external pin and watchdog. Each sets its own sticky flag in a byte-wide reset-cause register. A power-on event also wipes the other two flags and returns the monitor control to its idle state. Software reads the register early after start-up to learn the reset source, then clears the flags by writing zeros. Flags that are cleared before the next reset identify that next reset without ambiguity.

The monitor part receives a trip level from an abstracted comparator. A three-bit level code decides what a trip does. The code can switch the monitor off, or make a trip request a power-on style reset without setting any flag, or make a trip latch a monitor flag that drives an interrupt when the interrupt is enabled. Code values above 4 are illegal and a write carrying one leaves the stored code unchanged. Both registers sit on a simple byte-wide bus. Writes are synchronous and read data is combinational on the address. The register contents are also brought out as direct outputs.

Top module: `rstcause_vmon`

## Requirements
- R1: Address 0x3B reads the reset-cause byte with the power-on flag in bit 0, the external flag in bit 1 and the watchdog flag in bit 3. Bits 7:4 and bit 2 always read 0, even after a write of ones.
- R2: A power-on pulse sets bit 0 and clears bits 1 and 3 at the next clock edge. It takes precedence over external or watchdog pulses in the same cycle.
- R3: An external pulse sets bit 1 and a watchdog pulse sets bit 3 at the next clock edge. Neither pulse alters the other flags.
- R4: Writing 0 to a flag bit at 0x3B clears it and writing 1 has no effect. The power-on flag is cleared by nothing except such a write.
- R5: When a flag's set pulse and a write of 0 to that flag fall in the same cycle, the flag ends up set.
- R6: Address 0x3A reads the monitor control byte: level code in bits 2:0, interrupt enable in bit 4, monitor flag in bit 5, all other bits 0. A write with a legal code (0 to 4) stores the code and the enable at the next edge.
- R7: A write to 0x3A whose code is 5, 6 or 7 keeps the previous code, while the enable bit is still updated from that write.
- R8: With code 0, a trip changes neither the monitor flag nor the reset request.
- R9: With code 1, a trip drives the reset request high in the cycle after the trip and does not set the monitor flag.
- R10: With code 2, 3 or 4, a trip sets the monitor flag. The interrupt output is high exactly when the flag and the enable are both 1.
- R11: Writing 1 to bit 5 at 0x3A clears the monitor flag and writing 0 there leaves it. A trip in the same cycle as the clearing write leaves the flag set.
- R12: A power-on pulse returns the code, the enable, the monitor flag and the reset request to 0 at the next edge, even if a trip arrives in the same cycle.
- R13: While the asynchronous reset is asserted, all flags, control fields and outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset for initial state |
| por_evt | input | 1 | Power-on reset event pulse |
| ext_evt | input | 1 | External pin reset event pulse |
| wdt_evt | input | 1 | Watchdog reset event pulse |
| vlm_trip | input | 1 | Trip level from the supply comparator |
| bus_addr | input | 6 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| rst_flags | output | 8 | Reset-cause register contents |
| vlm_level | output | 3 | Stored level code |
| vlm_flag | output | 1 | Monitor flag |
| vlm_ie | output | 1 | Monitor interrupt enable |
| vlm_irq | output | 1 | Monitor interrupt |
| vlm_por_req | output | 1 | Request for a power-on style reset |

## Verification
The hardest cases are collisions inside one clock cycle. These include a set pulse meeting a clearing write on the same flag, a trip meeting a write-one-to-clear, and a power-on pulse meeting external, watchdog or trip inputs. They only show up when the pulse and the bus write land on the same edge. The driver task therefore takes every input for one cycle at once, and the reference model updates from the pre-edge state. Each collision is built deliberately, and both registers are then read back. Illegal-code writes carry a changed enable bit, so the read-back shows that part of the write was taken and part was refused.

// File: rtl/rcv_pkg.sv
package rcv_pkg;
  localparam int DW = 8;
  localparam int LW = 3;

  localparam int FB_POR = 0;
  localparam int FB_EXT = 1;
  localparam int FB_WDT = 3;
  localparam int CB_IE  = 4;
  localparam int CB_VF  = 5;

  localparam logic [LW-1:0] LVL_OFF   = 3'd0;
  localparam logic [LW-1:0] LVL_RESET = 3'd1;
  localparam logic [LW-1:0] LVL_MAX   = 3'd4;

  function automatic logic lvl_legal(input logic [LW-1:0] c);
    return c <= LVL_MAX;
  endfunction

  function automatic logic lvl_forces_reset(input logic [LW-1:0] c);
    return c == LVL_RESET;
  endfunction

  function automatic logic lvl_sets_flag(input logic [LW-1:0] c);
    return (c > LVL_RESET) && (c <= LVL_MAX);
  endfunction

  function automatic logic [DW-1:0] pack_flags(input logic porf, input logic extrf,
                                               input logic wdrf);
    logic [DW-1:0] b;
    b = '0;
    b[FB_POR] = porf;
    b[FB_EXT] = extrf;
    b[FB_WDT] = wdrf;
    return b;
  endfunction

  function automatic logic [DW-1:0] pack_ctrl(input logic [LW-1:0] code, input logic ie,
                                              input logic vf);
    logic [DW-1:0] b;
    b = '0;
    b[LW-1:0] = code;
    b[CB_IE]  = ie;
    b[CB_VF]  = vf;
    return b;
  endfunction
endpackage

// File: rtl/rcv_decode.sv
module rcv_decode
  import rcv_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 6'h3B,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'h3A
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DW-1:0]     flag_byte,
  input  logic [DW-1:0]     ctrl_byte,
  output logic              flag_wr,
  output logic              ctrl_wr,
  output logic [DW-1:0]     rdata
);
  logic flag_sel, ctrl_sel;

  assign flag_sel = (addr == FLAG_ADDR);
  assign ctrl_sel = (addr == CTRL_ADDR);
  assign flag_wr  = wr & flag_sel;
  assign ctrl_wr  = wr & ctrl_sel;

  always_comb begin
    rdata = '0;
    if (flag_sel)      rdata = flag_byte;
    else if (ctrl_sel) rdata = ctrl_byte;
  end
endmodule

// File: rtl/rcv_flags.sv
module rcv_flags
  import rcv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic por_evt,
  input  logic ext_evt,
  input  logic wdt_evt,
  input  logic wr,
  input  logic keep_por,
  input  logic keep_ext,
  input  logic keep_wdt,
  output logic porf,
  output logic extrf,
  output logic wdrf
);
  localparam int NSEC = 2;

  logic            por_set;
  logic [NSEC-1:0] sec_set;
  logic [NSEC-1:0] sec_keep;
  logic [NSEC-1:0] sec_q;

  assign por_set  = por_evt;
  assign sec_set  = {wdt_evt & ~por_evt, ext_evt & ~por_evt};
  assign sec_keep = {keep_wdt, keep_ext};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       porf <= 1'b0;
    else if (por_set) porf <= 1'b1;
    else if (wr)      porf <= porf & keep_por;
  end

  for (genvar gi = 0; gi < NSEC; gi++) begin : g_sec
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            q <= 1'b0;
      else if (por_evt)      q <= 1'b0;
      else if (sec_set[gi])  q <= 1'b1;
      else if (wr)           q <= q & sec_keep[gi];
    end
    assign sec_q[gi] = q;
  end

  assign extrf = sec_q[0];
  assign wdrf  = sec_q[1];

  p_por_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    por_evt |=> (porf && !extrf && !wdrf));
  p_ext_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_evt && !por_evt) |=> extrf);
  p_wdt_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_evt && !por_evt) |=> wdrf);
  p_porf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (porf && !(wr && !keep_por)) |=> porf);
  p_w1_noeffect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!extrf && !ext_evt && !por_evt) |=> !extrf);
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !keep_wdt && wdt_evt && !por_evt) |=> wdrf);
endmodule

// File: rtl/rcv_monitor.sv
module rcv_monitor
  import rcv_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          por_evt,
  input  logic          trip,
  input  logic          wr,
  input  logic [LW-1:0] wcode,
  input  logic          wie,
  input  logic          wclr,
  output logic [LW-1:0] code,
  output logic          ie,
  output logic          vflag,
  output logic          irq,
  output logic          por_req
);
  logic code_ok;
  logic trip_flag;
  logic trip_reset;
  logic flag_clr;

  assign code_ok    = lvl_legal(wcode);
  assign trip_flag  = trip & lvl_sets_flag(code);
  assign trip_reset = trip & lvl_forces_reset(code);
  assign flag_clr   = wr & wclr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= LVL_OFF;
      ie   <= 1'b0;
    end else if (por_evt) begin
      code <= LVL_OFF;
      ie   <= 1'b0;
    end else if (wr) begin
      ie <= wie;
      if (code_ok) code <= wcode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         vflag <= 1'b0;
    else if (por_evt)   vflag <= 1'b0;
    else if (trip_flag) vflag <= 1'b1;
    else if (flag_clr)  vflag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       por_req <= 1'b0;
    else if (por_evt) por_req <= 1'b0;
    else              por_req <= trip_reset;
  end

  assign irq = vflag & ie;

  p_code_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> lvl_legal(code));
  p_illegal_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !code_ok && !por_evt) |=> (code == $past(code)));
  p_off_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (code == LVL_OFF && !por_evt && !flag_clr) |=> ($stable(vflag) && !por_req));
  p_reset_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && code == LVL_RESET && !por_evt) |=> por_req);
  p_reset_noflag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (code == LVL_RESET && !vflag) |=> !vflag);
  p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && lvl_sets_flag(code) && !por_evt) |=> vflag);
  p_w1c_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !trip && !por_evt) |=> !vflag);
  p_por_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    por_evt |=> (code == LVL_OFF && !ie && !vflag && !por_req));
endmodule

// File: rtl/rstcause_vmon.sv
module rstcause_vmon
  import rcv_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 6'h3B,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'h3A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_evt,
  input  logic              ext_evt,
  input  logic              wdt_evt,
  input  logic              vlm_trip,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [7:0]        rst_flags,
  output logic [2:0]        vlm_level,
  output logic              vlm_flag,
  output logic              vlm_ie,
  output logic              vlm_irq,
  output logic              vlm_por_req
);
  logic          flag_wr, ctrl_wr;
  logic          porf, extrf, wdrf;
  logic [LW-1:0] code;
  logic          ie, vflag;
  logic [DW-1:0] flag_byte, ctrl_byte;

  assign flag_byte = pack_flags(porf, extrf, wdrf);
  assign ctrl_byte = pack_ctrl(code, ie, vflag);

  rcv_decode #(
    .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR), .CTRL_ADDR(CTRL_ADDR)
  ) u_decode (
    .addr(bus_addr), .wr(bus_wr), .flag_byte(flag_byte), .ctrl_byte(ctrl_byte),
    .flag_wr(flag_wr), .ctrl_wr(ctrl_wr), .rdata(bus_rdata)
  );

  rcv_flags u_flags (
    .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .ext_evt(ext_evt), .wdt_evt(wdt_evt),
    .wr(flag_wr), .keep_por(bus_wdata[FB_POR]), .keep_ext(bus_wdata[FB_EXT]),
    .keep_wdt(bus_wdata[FB_WDT]), .porf(porf), .extrf(extrf), .wdrf(wdrf)
  );

  rcv_monitor u_monitor (
    .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .trip(vlm_trip), .wr(ctrl_wr),
    .wcode(bus_wdata[LW-1:0]), .wie(bus_wdata[CB_IE]), .wclr(bus_wdata[CB_VF]),
    .code(code), .ie(ie), .vflag(vflag), .irq(vlm_irq), .por_req(vlm_por_req)
  );

  assign rst_flags = flag_byte;
  assign vlm_level = code;
  assign vlm_flag  = vflag;
  assign vlm_ie    = ie;

  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_flags[7:4] == 4'h0) && !rst_flags[2]);
endmodule

// File: tb/rstcause_vmon_bench.sv
module rstcause_vmon_bench;
  localparam logic [5:0] A_FLAG = 6'h3B;
  localparam logic [5:0] A_CTRL = 6'h3A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       por_evt = 0, ext_evt = 0, wdt_evt = 0, vlm_trip = 0;
  logic [5:0] bus_addr = '0;
  logic       bus_wr = 0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, rst_flags;
  logic [2:0] vlm_level;
  logic       vlm_flag, vlm_ie, vlm_irq, vlm_por_req;

  always #2.5 clk = ~clk;

  rstcause_vmon u_rstcause_vmon (
    .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .ext_evt(ext_evt), .wdt_evt(wdt_evt),
    .vlm_trip(vlm_trip), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rst_flags(rst_flags), .vlm_level(vlm_level),
    .vlm_flag(vlm_flag), .vlm_ie(vlm_ie), .vlm_irq(vlm_irq), .vlm_por_req(vlm_por_req)
  );

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t q[$];

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  bit m_por, m_ext, m_wdt, m_ie, m_vf, m_req;
  logic [2:0] m_code;

  function automatic logic [7:0] m_flags_byte();
    return {4'h0, m_wdt, 1'b0, m_ext, m_por};
  endfunction
  function automatic logic [7:0] m_ctrl_byte();
    return {2'b00, m_vf, m_ie, 1'b0, m_code};
  endfunction

  // monitor: compares queued expectations one time unit after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        case (it.kind)
          0: act = bus_rdata;
          1: act = {7'd0, vlm_irq};
          default: act = {7'd0, vlm_por_req};
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic push(input int kind, input logic [7:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  // one cycle of stimulus; model advances from the pre-edge state
  task automatic drive(input bit p, input bit e, input bit w, input bit t,
                       input bit wr, input logic [5:0] a, input logic [7:0] d);
    bit fw, cw;
    logic [2:0] oc;
    por_evt = p; ext_evt = e; wdt_evt = w; vlm_trip = t;
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    fw = wr && (a == A_FLAG);
    cw = wr && (a == A_CTRL);
    oc = m_code;
    if (p) begin
      m_por = 1; m_ext = 0; m_wdt = 0; m_code = 0; m_ie = 0; m_vf = 0; m_req = 0;
    end else begin
      if (fw) begin
        m_por = m_por & d[0];
        m_ext = m_ext & d[1];
        m_wdt = m_wdt & d[3];
      end
      if (e) m_ext = 1;
      if (w) m_wdt = 1;
      if (cw) begin
        m_ie = d[4];
        if (d[2:0] <= 3'd4) m_code = d[2:0];
        if (d[5]) m_vf = 0;
      end
      if (t && oc >= 3'd2 && oc <= 3'd4) m_vf = 1;
      m_req = t && (oc == 3'd1);
    end
    @(negedge clk);
    por_evt = 0; ext_evt = 0; wdt_evt = 0; vlm_trip = 0; bus_wr = 0;
  endtask

  task automatic check_all(input string tag);
    bus_addr = A_FLAG;
    push(0, m_flags_byte(), tag);
    push(1, {7'd0, m_ie & m_vf}, tag);
    push(2, {7'd0, m_req}, tag);
    drive(0, 0, 0, 0, 0, A_FLAG, 8'h00);
    bus_addr = A_CTRL;
    push(0, m_ctrl_byte(), tag);
    drive(0, 0, 0, 0, 0, A_CTRL, 8'h00);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_por = 0; m_ext = 0; m_wdt = 0; m_ie = 0; m_vf = 0; m_req = 0; m_code = 0;
    repeat (3) @(negedge clk);
    // R13: state under reset
    push(0, 8'h00, "R13 flags in reset");
    push(1, 8'h00, "R13 irq in reset");
    push(2, 8'h00, "R13 req in reset");
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R13 after release");

    drive(1, 0, 0, 0, 0, A_FLAG, 0);             check_all("R2 por sets bit0");
    drive(0, 1, 0, 0, 0, A_FLAG, 0);             check_all("R3 ext sets bit1");
    drive(0, 0, 1, 0, 0, A_FLAG, 0);             check_all("R3 wdt sets bit3");
    drive(0, 0, 0, 0, 1, A_FLAG, 8'hFF);         check_all("R1 R4 ones write no effect, reserved zero");
    drive(1, 1, 1, 0, 0, A_FLAG, 0);             check_all("R2 por beats ext and wdt");
    drive(0, 1, 1, 0, 0, A_FLAG, 0);
    drive(0, 0, 0, 0, 1, A_FLAG, 8'hFE);         check_all("R4 clear porf by zero");
    drive(0, 0, 0, 0, 1, A_FLAG, 8'h00);         check_all("R4 clear all flags");
    drive(0, 1, 1, 0, 0, A_FLAG, 0);             check_all("R4 porf not set by ext or wdt");
    drive(0, 0, 0, 0, 1, A_FLAG, 8'h00);
    drive(0, 1, 0, 0, 1, A_FLAG, 8'hF5);         check_all("R5 ext set beats clear");
    drive(0, 0, 1, 0, 1, A_FLAG, 8'h00);         check_all("R5 wdt set beats clear");

    drive(0, 0, 0, 0, 1, A_CTRL, 8'hD2);         check_all("R6 code 2 ie 1 reserved zero");
    drive(0, 0, 0, 0, 1, A_CTRL, 8'h07);         check_all("R7 illegal 7 keeps code");
    drive(0, 0, 0, 0, 1, A_CTRL, 8'h15);         check_all("R7 illegal 5 keeps code");
    drive(0, 0, 0, 0, 1, A_CTRL, 8'h00);
    drive(0, 0, 0, 1, 0, A_CTRL, 0);             check_all("R8 off trip ignored");
    drive(0, 0, 0, 0, 1, A_CTRL, 8'h11);
    drive(0, 0, 0, 1, 0, A_CTRL, 0);
    bus_addr = A_CTRL;
    push(2, 8'h01, "R9 reset request follows trip");
    push(0, 8'h11, "R9 no flag with code 1");
    drive(0, 0, 0, 0, 0, A_CTRL, 0);
    check_all("R9 request drops");
    drive(0, 0, 0, 0, 1, A_CTRL, 8'h03);
    drive(0, 0, 0, 1, 0, A_CTRL, 0);             check_all("R10 code 3 trip sets flag irq off");
    drive(0, 0, 0, 0, 1, A_CTRL, 8'h13);         check_all("R10 R11 enable raises irq, zero keeps flag");
    drive(0, 0, 0, 1, 1, A_CTRL, 8'h33);         check_all("R11 trip beats w1c");
    drive(0, 0, 0, 0, 1, A_CTRL, 8'h33);         check_all("R11 w1c clears flag");
    drive(0, 0, 0, 0, 1, A_CTRL, 8'h14);
    drive(0, 0, 0, 1, 0, A_CTRL, 0);             check_all("R10 code 4 trip irq");
    drive(0, 0, 0, 0, 1, A_CTRL, 8'h12);
    drive(1, 0, 0, 1, 0, A_CTRL, 0);             check_all("R12 por clears monitor despite trip");
    drive(0, 0, 0, 0, 1, A_CTRL, 8'h11);
    drive(0, 0, 0, 1, 0, A_CTRL, 0);
    drive(1, 0, 0, 0, 0, A_CTRL, 0);             check_all("R12 por drops reset request");

    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule